// File: doc/BRIEF.md
# Stack Bytecode Execution Sequencer

This block is the control core of a small stack machine that runs a reduced integer subset of standard JVM bytecodes. Bytes come from a program memory on their own address bus. Operand-stack words and frame-local variables sit in a separate data memory. The core fetches an opcode and decodes it. It gathers any immediate bytes, moves stack words through the data port, and hands arithmetic to an external ALU over a request/result port. It updates its program counter and stack pointer with adders of its own.

The decoder sorts every supported opcode into one of four fixed execution lengths: 3, 4, 7 or 14 cycles. The control sequence is chosen per length class rather than per opcode. The frame base address is an input, because calls and returns belong to a neighbouring frame unit. A sleep opcode parks the core until a wake request arrives. Any opcode outside the subset stops the core and raises a flag.

The stack grows upward. The stack pointer names the next free word. Each push writes at the stack pointer and then advances it by one word. Each pop first decrements it and then reads that word.

Top module: `sbx_seq`

## Requirements
- R1: While reset is held, the program address is 0 and there are no data writes, no sleep indication, no illegal flag and no completion pulse. The first push after reset lands at data address SP_RESET (default 0x40).
- R2: The constant opcodes 0x02..0x08 push the values -1..5 (opcode minus 3). Opcode 0x10 pushes its next byte, sign-extended. The pop opcode 0x57 drops the top word, and the duplicate opcode 0x59 pushes a copy of the top word.
- R3: instr_done is high in the last cycle of each instruction, counting from its fetch cycle. Instructions take 3 cycles for nop (0x00), constants, 0x10, 0x57, 0x59 and sleep. They take 4 cycles for local loads, local stores and goto, and 7 cycles for arithmetic and compare-with-zero branches. Two-operand compare branches take 14 cycles.
- R4: An arithmetic opcode pops B (the top) and then A, issues the ALU with alu_a=A and alu_b=B, and pushes alu_y. Each opcode maps to an alu_op code: 0x60 uses 0 (add), 0x64 uses 1 (sub), 0x68 uses 2 (mul), 0x7E uses 3 (and), 0x80 uses 4 (or), 0x82 uses 5 (xor), 0x78 uses 6 (shift left), 0x7A uses 7 (arithmetic shift right) and 0x7C uses 8 (logical shift right). The negate opcode 0x74 pops only B and issues code 1 with A=0.
- R5: Local loads push the word at frame_base + index, and local stores pop into frame_base + index. The index is the next byte for 0x15 (load) and 0x36 (store). For the short forms 0x1A..0x1D (load) and 0x3B..0x3E (store), the index is 0..3.
- R6: goto (0xA7) sets the program counter to the opcode's own address plus a signed 16-bit offset, taken from the two following bytes with the high byte first. Both forward and backward offsets are supported.
- R7: Opcodes 0x99..0x9E pop one word and compare it, signed, with zero, under the conditions eq, ne, lt, ge, gt and le in that order. When the condition holds they branch as in R6. When it fails, execution continues at the opcode address plus 3.
- R8: Opcodes 0x9F..0xA4 pop B and then A, and compare A with B as signed values under the same condition order as R7. They branch or fall through in the same way.
- R9: After the sleep opcode 0xFE completes, sleeping is high. The program address then holds still and there are no data writes until wake is sampled high. Fetch resumes on the next cycle at the byte following the sleep opcode.
- R10: Any opcode not listed in R2..R9 sets illegal and halts the core. After that there are no data writes, no ALU requests and no instruction completions, and the program address stays on the offending byte until reset.
- R11: alu_req is high for exactly one cycle per arithmetic instruction and at no other time. Branch compares and all address arithmetic are done without the ALU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | PC_W | Program memory byte address |
| rom_data | input | 8 | Program byte at rom_addr (same-cycle read) |
| ram_addr | output | DADDR_W | Data memory word address |
| ram_we | output | 1 | Data memory write enable |
| ram_wdata | output | DATA_W | Data memory write word |
| ram_rdata | input | DATA_W | Data word at ram_addr (same-cycle read) |
| frame_base | input | DADDR_W | Base address of the current method's locals |
| alu_req | output | 1 | ALU operation request |
| alu_op | output | 4 | ALU operation code (R4) |
| alu_a | output | DATA_W | ALU first operand |
| alu_b | output | DATA_W | ALU second operand |
| alu_y | input | DATA_W | ALU result (same cycle) |
| wake | input | 1 | Wake request for the sleeping core |
| sleeping | output | 1 | Core suspended by the sleep opcode |
| illegal | output | 1 | Unsupported opcode seen; core halted |
| instr_done | output | 1 | Last cycle of an instruction |

## Verification
The program mixes forward and backward jumps with taken and untaken conditional branches. Every wrongly chosen target holds an unsupported opcode, so a bad offset base or a reversed condition halts the core, and the remaining scoreboard writes then go missing. A two-operand compare of -3 against 1 tells signed from unsigned comparison: an unsigned compare falls through and runs into a halt byte. Sign extension of 0x80 and 0xFD, popping operands in the wrong order (visible through subtraction), and a stack pointer that is off by one all show up as wrong write addresses or data. Cycle counts per instruction expose a wrong latency class. The sleep window and the halt window catch a core that keeps fetching or writing.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

   typedef enum logic [1:0] {CLS3, CLS4, CLS7, CLS14} lat_cls_e;

   typedef enum logic [3:0] {
      K_NOP, K_CONST, K_PUSH8, K_LOAD, K_STORE, K_DUP, K_POP,
      K_ARITH, K_GOTO, K_IFZ, K_IFCMP, K_SLEEP, K_BAD
   } kind_e;

   typedef enum logic [3:0] {
      ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_MUL = 4'd2, ALU_AND = 4'd3,
      ALU_OR  = 4'd4, ALU_XOR = 4'd5, ALU_SHL = 4'd6, ALU_SHR = 4'd7,
      ALU_USHR = 4'd8
   } alu_op_e;

   typedef enum logic [1:0] {S_RUN, S_SLEEP, S_HALT} core_st_e;

   typedef struct packed {
      kind_e               kind;
      lat_cls_e            cls;
      alu_op_e             aop;
      logic                unary;
      logic [2:0]          cond;
      logic [1:0]          slot;
      logic                has_idx;
      logic signed [3:0]   cval;
   } dec_t;

   localparam logic [7:0] OP_SLEEP = 8'hFE;

   // index of the final step of each latency class
   function automatic logic [3:0] cls_last(input lat_cls_e c);
      case (c)
         CLS3:    return 4'd2;
         CLS4:    return 4'd3;
         CLS7:    return 4'd6;
         default: return 4'd13;
      endcase
   endfunction

endpackage

// File: rtl/sbx_decode.sv
module sbx_decode
   import sbx_pkg::*;
(
   input  logic [7:0] op,
   output dec_t       dec
);
   always_comb begin
      dec         = '0;
      dec.kind    = K_BAD;
      dec.cls     = CLS3;
      dec.aop     = ALU_ADD;
      case (op) inside
         8'h00:           dec.kind = K_NOP;
         [8'h02:8'h08]: begin
            dec.kind = K_CONST;
            dec.cval = 4'(op - 8'd3);
         end
         8'h10:           dec.kind = K_PUSH8;
         8'h15: begin
            dec.kind = K_LOAD;  dec.cls = CLS4; dec.has_idx = 1'b1;
         end
         [8'h1A:8'h1D]: begin
            dec.kind = K_LOAD;  dec.cls = CLS4; dec.slot = op[1:0] + 2'd2;
         end
         8'h36: begin
            dec.kind = K_STORE; dec.cls = CLS4; dec.has_idx = 1'b1;
         end
         [8'h3B:8'h3E]: begin
            dec.kind = K_STORE; dec.cls = CLS4; dec.slot = op[1:0] + 2'd1;
         end
         8'h57:           dec.kind = K_POP;
         8'h59:           dec.kind = K_DUP;
         8'h60: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_ADD;  end
         8'h64: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_SUB;  end
         8'h68: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_MUL;  end
         8'h74: begin
            dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_SUB; dec.unary = 1'b1;
         end
         8'h78: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_SHL;  end
         8'h7A: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_SHR;  end
         8'h7C: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_USHR; end
         8'h7E: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_AND;  end
         8'h80: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_OR;   end
         8'h82: begin dec.kind = K_ARITH; dec.cls = CLS7; dec.aop = ALU_XOR;  end
         [8'h99:8'h9E]: begin
            dec.kind = K_IFZ;   dec.cls = CLS7;  dec.cond = 3'(op - 8'h99);
         end
         [8'h9F:8'hA4]: begin
            dec.kind = K_IFCMP; dec.cls = CLS14; dec.cond = 3'(op - 8'h9F);
         end
         8'hA7: begin dec.kind = K_GOTO; dec.cls = CLS4; end
         OP_SLEEP:        dec.kind = K_SLEEP;
         default:         dec.kind = K_BAD;
      endcase
   end
endmodule

// File: rtl/sbx_ptr_unit.sv
module sbx_ptr_unit #(
   parameter int PC_W     = 10,
   parameter int DADDR_W  = 8,
   parameter int SP_RESET = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pc_inc,
   input  logic               pc_load,
   input  logic [PC_W-1:0]    base_pc,
   input  logic [15:0]        offset,
   input  logic               sp_inc,
   input  logic               sp_dec,
   output logic [PC_W-1:0]    pc,
   output logic [DADDR_W-1:0] sp,
   output logic [DADDR_W-1:0] sp_m1
);
   logic [PC_W-1:0] off_w;

   generate
      if (PC_W <= 16) begin : g_off_trunc
         assign off_w = offset[PC_W-1:0];
      end else begin : g_off_sext
         assign off_w = {{(PC_W-16){offset[15]}}, offset};
      end
   endgenerate

   assign sp_m1 = sp - DADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0;
         sp <= DADDR_W'(SP_RESET);
      end else begin
         if (pc_load)      pc <= base_pc + off_w;
         else if (pc_inc)  pc <= pc + PC_W'(1);
         if (sp_inc)       sp <= sp + DADDR_W'(1);
         else if (sp_dec)  sp <= sp_m1;
      end
   end
endmodule

// File: rtl/sbx_seq.sv
module sbx_seq
   import sbx_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int PC_W     = 10,
   parameter int DADDR_W  = 8,
   parameter int SP_RESET = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PC_W-1:0]    rom_addr,
   input  logic [7:0]         rom_data,
   output logic [DADDR_W-1:0] ram_addr,
   output logic               ram_we,
   output logic [DATA_W-1:0]  ram_wdata,
   input  logic [DATA_W-1:0]  ram_rdata,
   input  logic [DADDR_W-1:0] frame_base,
   output logic               alu_req,
   output logic [3:0]         alu_op,
   output logic [DATA_W-1:0]  alu_a,
   output logic [DATA_W-1:0]  alu_b,
   input  logic [DATA_W-1:0]  alu_y,
   input  logic               wake,
   output logic               sleeping,
   output logic               illegal,
   output logic               instr_done
);
   localparam int STEP_W = 4;

   generate
      if (!(DATA_W == 8 || DATA_W == 16)) begin : g_bad_dw
         $error("sbx_seq: DATA_W must be 8 or 16");
      end
      if (PC_W < 4 || DADDR_W < 4) begin : g_bad_aw
         $error("sbx_seq: address widths too small");
      end
   endgenerate

   core_st_e            st;
   logic [STEP_W-1:0]   step;
   logic [7:0]          ir, imm_hi, imm_lo;
   logic [PC_W-1:0]     op_pc, pc;
   logic [DADDR_W-1:0]  sp, sp_m1;
   logic [DATA_W-1:0]   tmp, opa, opb;
   logic                bad;

   logic pc_inc, pc_load, sp_inc, sp_dec;
   logic ld_hi, ld_lo, ld_tmp_ram, ld_tmp_alu, ld_a, ld_b, zero_a;

   dec_t       dec;
   logic [7:0] cur_op;
   assign cur_op = (step == '0) ? rom_data : ir;

   sbx_decode u_dec (.op(cur_op), .dec(dec));

   sbx_ptr_unit #(.PC_W(PC_W), .DADDR_W(DADDR_W), .SP_RESET(SP_RESET)) u_ptr (
      .clk(clk), .rst_n(rst_n), .pc_inc(pc_inc), .pc_load(pc_load),
      .base_pc(op_pc), .offset({imm_hi, imm_lo}),
      .sp_inc(sp_inc), .sp_dec(sp_dec), .pc(pc), .sp(sp), .sp_m1(sp_m1)
   );

   logic run, last;
   assign run  = (st == S_RUN);
   assign last = (step != '0) && (step == cls_last(dec.cls));

   // frame-relative address, dedicated adder
   logic [7:0]         idx;
   logic [DADDR_W-1:0] loc_addr;
   assign idx      = dec.has_idx ? imm_lo : {6'd0, dec.slot};
   assign loc_addr = frame_base + DADDR_W'(idx);

   logic [DATA_W-1:0] const_w, imm_w;
   assign const_w = DATA_W'(dec.cval);
   generate
      if (DATA_W == 8) begin : g_imm_w8
         assign imm_w = imm_lo;
      end else begin : g_imm_wide
         assign imm_w = {{(DATA_W-8){imm_lo[7]}}, imm_lo};
      end
   endgenerate

   // branch condition, independent of the ALU
   logic signed [DATA_W-1:0] cmp_l, cmp_r;
   logic                     taken;
   assign cmp_l = (dec.kind == K_IFZ) ? opb : opa;
   assign cmp_r = (dec.kind == K_IFZ) ? '0  : opb;
   always_comb begin
      case (dec.cond)
         3'd0:    taken = (cmp_l == cmp_r);
         3'd1:    taken = (cmp_l != cmp_r);
         3'd2:    taken = (cmp_l <  cmp_r);
         3'd3:    taken = (cmp_l >= cmp_r);
         3'd4:    taken = (cmp_l >  cmp_r);
         3'd5:    taken = (cmp_l <= cmp_r);
         default: taken = 1'b0;
      endcase
   end

   assign alu_op = dec.aop;
   assign alu_a  = opa;
   assign alu_b  = opb;

   always_comb begin
      rom_addr = pc;        ram_addr = sp_m1;    ram_we = 1'b0;
      ram_wdata = tmp;      alu_req = 1'b0;
      pc_inc = 1'b0;  pc_load = 1'b0;  sp_inc = 1'b0;  sp_dec = 1'b0;
      ld_hi = 1'b0;  ld_lo = 1'b0;  ld_tmp_ram = 1'b0;  ld_tmp_alu = 1'b0;
      ld_a = 1'b0;   ld_b = 1'b0;   zero_a = 1'b0;
      if (run) begin
         if (step == '0) begin
            pc_inc = (dec.kind != K_BAD);
         end else begin
            case (dec.kind)
               K_CONST: if (step == 4'd1) begin
                  ram_addr = sp; ram_wdata = const_w; ram_we = 1'b1; sp_inc = 1'b1;
               end
               K_PUSH8: begin
                  if (step == 4'd1) begin ld_lo = 1'b1; pc_inc = 1'b1; end
                  if (step == 4'd2) begin
                     ram_addr = sp; ram_wdata = imm_w; ram_we = 1'b1; sp_inc = 1'b1;
                  end
               end
               K_LOAD: begin
                  if (step == 4'd1 && dec.has_idx) begin ld_lo = 1'b1; pc_inc = 1'b1; end
                  if (step == 4'd2) begin ram_addr = loc_addr; ld_tmp_ram = 1'b1; end
                  if (step == 4'd3) begin ram_addr = sp; ram_we = 1'b1; sp_inc = 1'b1; end
               end
               K_STORE: begin
                  if (step == 4'd1 && dec.has_idx) begin ld_lo = 1'b1; pc_inc = 1'b1; end
                  if (step == 4'd2) begin ld_tmp_ram = 1'b1; sp_dec = 1'b1; end
                  if (step == 4'd3) begin ram_addr = loc_addr; ram_we = 1'b1; end
               end
               K_DUP: begin
                  if (step == 4'd1) ld_tmp_ram = 1'b1;
                  if (step == 4'd2) begin ram_addr = sp; ram_we = 1'b1; sp_inc = 1'b1; end
               end
               K_POP: if (step == 4'd1) sp_dec = 1'b1;
               K_ARITH: begin
                  if (step == 4'd1) begin ld_b = 1'b1; sp_dec = 1'b1; end
                  if (step == 4'd2) begin
                     if (dec.unary) zero_a = 1'b1;
                     else begin ld_a = 1'b1; sp_dec = 1'b1; end
                  end
                  if (step == 4'd3) begin alu_req = 1'b1; ld_tmp_alu = 1'b1; end
                  if (step == 4'd4) begin ram_addr = sp; ram_we = 1'b1; sp_inc = 1'b1; end
               end
               K_GOTO, K_IFZ, K_IFCMP: begin
                  if (step == 4'd1) begin ld_hi = 1'b1; pc_inc = 1'b1; end
                  if (step == 4'd2) begin ld_lo = 1'b1; pc_inc = 1'b1; end
                  if (dec.kind == K_GOTO && step == 4'd3) pc_load = 1'b1;
                  if (dec.kind != K_GOTO && step == 4'd3) begin ld_b = 1'b1; sp_dec = 1'b1; end
                  if (dec.kind == K_IFZ && step == 4'd4) pc_load = taken;
                  if (dec.kind == K_IFCMP && step == 4'd4) begin ld_a = 1'b1; sp_dec = 1'b1; end
                  if (dec.kind == K_IFCMP && step == 4'd5) pc_load = taken;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_RUN;  step <= '0;  bad <= 1'b0;
         ir <= '0;  imm_hi <= '0;  imm_lo <= '0;  op_pc <= '0;
         tmp <= '0;  opa <= '0;  opb <= '0;
      end else begin
         case (st)
            S_RUN: begin
               if (step == '0) begin
                  if (dec.kind == K_BAD) begin
                     st <= S_HALT; bad <= 1'b1;
                  end else begin
                     ir <= rom_data; op_pc <= pc; step <= 4'd1;
                  end
               end else if (last) begin
                  step <= '0;
                  if (dec.kind == K_SLEEP) st <= S_SLEEP;
               end else begin
                  step <= step + 4'd1;
               end
            end
            S_SLEEP: if (wake) st <= S_RUN;
            default: ;
         endcase
         if (ld_hi)      imm_hi <= rom_data;
         if (ld_lo)      imm_lo <= rom_data;
         if (ld_tmp_ram) tmp <= ram_rdata;
         if (ld_tmp_alu) tmp <= alu_y;
         if (ld_b)       opb <= ram_rdata;
         if (ld_a)       opa <= ram_rdata;
         if (zero_a)     opa <= '0;
      end
   end

   assign sleeping   = (st == S_SLEEP);
   assign illegal    = bad;
   assign instr_done = run && last;

endmodule

// File: rtl/sbx_seq_chk.sv
module sbx_seq_chk #(
   parameter int PC_W = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] rom_addr,
   input logic            ram_we,
   input logic            alu_req,
   input logic            wake,
   input logic            sleeping,
   input logic            illegal,
   input logic            instr_done
);
   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> illegal);

   // R10
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!ram_we && !alu_req && !instr_done));

   // R9
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && !wake) |=> (sleeping && $stable(rom_addr)));

   // R9
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleeping |-> (!ram_we && !alu_req));

   // R9
   sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && wake) |=> !sleeping);

   // R3
   done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |=> !instr_done);
endmodule

bind sbx_seq sbx_seq_chk #(.PC_W(PC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .ram_we(ram_we),
   .alu_req(alu_req), .wake(wake), .sleeping(sleeping),
   .illegal(illegal), .instr_done(instr_done)
);

// File: tb/sbx_seq_tb_top.sv
`timescale 1ns/1ps
module sbx_seq_tb_top;
   localparam int DW = 16;
   localparam int PW = 10;
   localparam int AW = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, wake;
   logic [PW-1:0] rom_addr;
   logic [7:0]    rom_data;
   logic [AW-1:0] ram_addr;
   logic          ram_we;
   logic [DW-1:0] ram_wdata, ram_rdata;
   logic [AW-1:0] frame_base;
   logic          alu_req;
   logic [3:0]    alu_op;
   logic [DW-1:0] alu_a, alu_b, alu_y;
   logic          sleeping, illegal, instr_done;

   logic [7:0]    rom [0:(1<<PW)-1];
   logic [DW-1:0] ram [0:(1<<AW)-1];

   assign frame_base = 8'h10;
   assign rom_data   = rom[rom_addr];
   assign ram_rdata  = ram[ram_addr];
   always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

   // ALU model from the operation codes of R4
   always_comb begin
      case (alu_op)
         4'd0:    alu_y = alu_a + alu_b;
         4'd1:    alu_y = alu_a - alu_b;
         4'd2:    alu_y = alu_a * alu_b;
         4'd3:    alu_y = alu_a & alu_b;
         4'd4:    alu_y = alu_a | alu_b;
         4'd5:    alu_y = alu_a ^ alu_b;
         4'd6:    alu_y = alu_a << alu_b[3:0];
         4'd7:    alu_y = $signed(alu_a) >>> alu_b[3:0];
         4'd8:    alu_y = alu_a >> alu_b[3:0];
         default: alu_y = '0;
      endcase
   end

   sbx_seq #(.DATA_W(DW), .PC_W(PW), .DADDR_W(AW), .SP_RESET(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .frame_base(frame_base), .alu_req(alu_req),
      .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_y(alu_y),
      .wake(wake), .sleeping(sleeping), .illegal(illegal), .instr_done(instr_done)
   );

   int n_chk = 0, n_fail = 0;
   int pc_b = 0, cyc = 0, alu_cnt = 0;

   logic [AW-1:0] exp_a[$];
   logic [DW-1:0] exp_d[$];
   string         exp_wt[$];
   int            exp_lat[$];
   string         exp_lt[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      rom[pc_b] = b;
      pc_b++;
   endtask

   task automatic ins(input int lat, input string tag);
      exp_lat.push_back(lat);
      exp_lt.push_back(tag);
   endtask

   task automatic wr(input int a, input int d, input string tag);
      exp_a.push_back(AW'(a));
      exp_d.push_back(DW'(d));
      exp_wt.push_back(tag);
   endtask

   // monitor: compare writes and instruction lengths against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_we) begin
            if (exp_a.size() == 0)
               chk(1'b0, "R10", "unexpected write {addr,data}",
                   {ram_addr, ram_wdata}, 0);
            else begin
               logic [AW-1:0] ea;
               logic [DW-1:0] ed;
               string         et;
               ea = exp_a.pop_front();
               ed = exp_d.pop_front();
               et = exp_wt.pop_front();
               chk(ram_addr == ea && ram_wdata == ed, et, "write {addr,data}",
                   {ram_addr, ram_wdata}, {ea, ed});
            end
         end
         if (alu_req) alu_cnt++;
         if (!sleeping && !illegal) begin
            cyc++;
            if (instr_done) begin
               if (exp_lat.size() == 0)
                  chk(1'b0, "R3", "unexpected completion", cyc, 0);
               else begin
                  int    el;
                  string lt;
                  el = exp_lat.pop_front();
                  lt = exp_lt.pop_front();
                  chk(cyc == el, lt, "instruction cycles", cyc, el);
               end
               cyc = 0;
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [PW-1:0] hold_pc;
      bit            quiet;
      rst_n = 1'b0;
      wake  = 1'b0;
      for (int i = 0; i < (1<<PW); i++) rom[i] = 8'hFF;
      for (int i = 0; i < (1<<AW); i++) ram[i] = '0;
      ram[8'h12] = 16'h1234;
      ram[8'h15] = 16'h00AB;

      // program and scoreboard, sp starts at 0x40
      put(8'h02);              ins(3, "R2"); wr('h40, 'hFFFF, "R1");
      put(8'h08);              ins(3, "R3"); wr('h41, 'h0005, "R2");
      put(8'h10); put(8'h80);  ins(3, "R2"); wr('h42, 'hFF80, "R2");
      put(8'h10); put(8'h7F);  ins(3, "R2"); wr('h43, 'h007F, "R2");
      put(8'h60);              ins(7, "R3"); wr('h42, 'hFFFF, "R4");
      put(8'h64);              ins(7, "R3"); wr('h41, 'h0006, "R4");
      put(8'h1C);              ins(4, "R3"); wr('h42, 'h1234, "R5");
      put(8'h15); put(8'h05);  ins(4, "R5"); wr('h43, 'h00AB, "R5");
      put(8'h82);              ins(7, "R4"); wr('h42, 'h129F, "R4");
      put(8'h59);              ins(3, "R2"); wr('h43, 'h129F, "R2");
      put(8'h3B);              ins(4, "R5"); wr('h10, 'h129F, "R5");
      put(8'h36); put(8'h07);  ins(4, "R5"); wr('h17, 'h129F, "R5");
      put(8'h74);              ins(7, "R4"); wr('h41, 'hFFFA, "R4");
      put(8'h68);              ins(7, "R4"); wr('h40, 'h0006, "R4");
      put(8'h06);              ins(3, "R2"); wr('h41, 'h0003, "R2");
      put(8'h78);              ins(7, "R4"); wr('h40, 'h0030, "R4");
      put(8'h57);              ins(3, "R2");
      // 21: goto +5 -> 26
      put(8'hA7); put(8'h00); put(8'h05); ins(4, "R6");
      put(8'hFF); put(8'hFF);
      put(8'h03);              ins(3, "R2"); wr('h40, 'h0000, "R2");
      // 27: ifeq taken -> 31
      put(8'h99); put(8'h00); put(8'h04); ins(7, "R7");
      put(8'hFF);
      put(8'h04);              ins(3, "R2"); wr('h40, 'h0001, "R2");
      // 32: ifeq not taken -> 35
      put(8'h99); put(8'h00); put(8'h0A); ins(7, "R7");
      put(8'h02);              ins(3, "R2"); wr('h40, 'hFFFF, "R2");
      // 36: iflt taken -> 40
      put(8'h9B); put(8'h00); put(8'h04); ins(7, "R7");
      put(8'hFF);
      put(8'h05);              ins(3, "R2"); wr('h40, 'h0002, "R2");
      put(8'h07);              ins(3, "R2"); wr('h41, 'h0004, "R2");
      // 42: 2 > 4 false -> 45
      put(8'hA3); put(8'h00); put(8'h0A); ins(14, "R8");
      put(8'h10); put(8'hFD);  ins(3, "R2"); wr('h40, 'hFFFD, "R2");
      put(8'h04);              ins(3, "R2"); wr('h41, 'h0001, "R2");
      // 48: -3 < 1 signed true -> 52
      put(8'hA1); put(8'h00); put(8'h04); ins(14, "R8");
      put(8'hFF);
      put(8'hFE);              ins(3, "R9");
      put(8'h05);              ins(3, "R9"); wr('h40, 'h0002, "R9");
      // 54: goto +8 -> 62; 62: goto -5 -> 57; 58: goto +8 -> 66 (illegal)
      put(8'hA7); put(8'h00); put(8'h08);
      put(8'h08);
      put(8'hA7); put(8'h00); put(8'h08);
      put(8'hFF);
      put(8'hA7); put(8'hFF); put(8'hFB);
      put(8'hFF);
      put(8'hFF);
      ins(4, "R6"); ins(4, "R6");
      ins(3, "R6"); wr('h41, 'h0005, "R6");
      ins(4, "R6");

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rom_addr == 0, "R1", "rom_addr in reset", rom_addr, 0);
      chk(ram_we == 0, "R1", "ram_we in reset", ram_we, 0);
      chk(sleeping == 0 && illegal == 0 && instr_done == 0, "R1",
          "flags in reset", {sleeping, illegal, instr_done}, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (sleeping) break;
      end
      chk(sleeping == 1'b1, "R9", "sleeping after sleep opcode", sleeping, 1);
      chk(rom_addr == 53, "R9", "address held while asleep", rom_addr, 53);
      hold_pc = rom_addr;
      quiet   = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!sleeping || rom_addr != hold_pc || ram_we) quiet = 1'b0;
      end
      chk(quiet, "R9", "core idle while asleep", quiet, 1);
      @(posedge clk);
      #1 wake = 1'b1;
      @(posedge clk);
      #1 wake = 1'b0;
      @(negedge clk);
      chk(sleeping == 1'b0, "R9", "awake after wake", sleeping, 0);

      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (illegal) break;
      end
      chk(illegal == 1'b1, "R10", "illegal flag", illegal, 1);
      quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!illegal || rom_addr != 66 || instr_done || alu_req) quiet = 1'b0;
      end
      chk(quiet, "R10", "halted core idle at byte 66", rom_addr, 66);
      chk(exp_a.size() == 0, "R4", "pending expected writes", exp_a.size(), 0);
      chk(exp_lat.size() == 0, "R3", "pending completions", exp_lat.size(), 0);
      chk(alu_cnt == 6, "R11", "ALU request count", alu_cnt, 6);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule